// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the per-channel control and interrupt register bank of a descriptor-driven DMA controller. A 32-bit memory-mapped bus reaches it. The upper address bits select a channel, and each channel owns an 8 KiB window. Inside the window, a word index picks one of the channel's registers. Each channel holds descriptor pointers, a configuration word, a command word, a stream command word, an interrupt mask and a raw interrupt vector. From these it derives a one-hot channel state, a read-only status word, a masked interrupt vector and a single interrupt line.

The descriptor engines that move the data sit outside this block. They send in interrupt-set pulses, a live end-of-list flag, a command-source code and a pulse that marks the channel as running. In return, the bank gives them a one-cycle continue pulse for each command write. It also gives them one-cycle pulses that decode the stream command: one for a descriptor load and one for a burst start.

Top module: `dmareg_bank`

## Requirements
- R1: The channel index is bus address bits [12+k:13], where k is the width of the channel field. The register word index is address bits [7:2]. Address bits [12:8] and [1:0] are ignored, so an aliased address reaches the same register. A write to one channel leaves every other channel unchanged.
- R2: Byte offsets 0x00, 0x58, 0x5C, 0x60, 0x7C, 0x80, 0x84, 0x8C and 0x9C are 32-bit read/write registers that read back the last full-word value written. An offset that decodes to no register reads zero. Read data and `rd_valid` appear in the cycle after the request.
- R3: The channel state is one-hot: reset = 3'b001, stopped = 3'b010, running = 3'b100. Its reset value is the reset state. A configuration write (offset 0x84) with bit 0 clear forces the reset state. With bit 0 set and bit 1 set it forces the stopped state. With bit 0 set and bit 1 clear it leaves the state unchanged. Otherwise an `eng_run` pulse sets the running state. A configuration write in the same cycle as `eng_run` takes priority.
- R4: The status word (offset 0x88) is read-only and ignores writes. It holds the state in bits [2:0], the end-of-list flag in bit 5 and the command source in bits [8+SRC_W-1:8]. All other bits are zero. Out of reset with a command source of 1, it reads 0x101.
- R5: A write to the acknowledge register (offset 0x90) clears the raw interrupt bits that are set in the written value. The acknowledge register always reads zero.
- R6: The masked interrupt vector (offset 0x98) is raw (offset 0x94) AND mask (offset 0x8C, low IRQ_W bits). It is recomputed on every mask write, acknowledge write and set pulse, and takes effect after the same clock edge as the raw update. `irq` is high exactly when the masked vector is non-zero. Writes to the raw and masked offsets are ignored.
- R7: If an interrupt-set pulse and an acknowledge of the same bit fall in the same cycle, the bit ends set.
- R8: Every command write (offset 0x80) produces a one-cycle `cont_pulse` for that channel in the next cycle. `cmd_bad` pulses with it when any of bits [31:1] of the written value is set.
- R9: A stream command write (offset 0x9C) whose low 10 bits intersect 0x140 produces a one-cycle `desc_load` pulse. If bit 5 (0x20) is also set, `burst_start` pulses with it. Bit 5 alone produces no pulse.
- R10: An access whose byte enables are not all ones does not write. If it is a read, it returns zero with `rd_valid`. In either case it raises `bus_err` for one cycle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13+CHB | Byte address; bits above 12 select the channel |
| bus_be | input | 4 | Byte enables; only 4'hF is a legal access |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the read request |
| rd_data | output | 32 | Read data |
| bus_err | output | 1 | Narrow-access error pulse |
| eng_irq_set | input | NCH*IRQ_W | Interrupt-set pulses, IRQ_W bits per channel |
| eng_eol | input | NCH | Live end-of-list flag per channel |
| eng_run | input | NCH | Pulse: channel entered running |
| cmd_src | input | NCH*SRC_W | Command source code per channel |
| irq | output | NCH | Interrupt line per channel |
| cont_pulse | output | NCH | Continue request after a command write |
| cmd_bad | output | NCH | Command write carried bits other than bit 0 |
| desc_load | output | NCH | Stream command requests a descriptor load |
| burst_start | output | NCH | Stream command requests load plus start |

## Verification
Two pairs of functions can fall in the same cycle, and the bench provokes both. In the first, an engine interrupt-set pulse and a bus acknowledge of the same bit are driven on one clock edge. The raw register, masked register and interrupt line must show the bit as set afterwards. In the second, an `eng_run` pulse and a configuration write with bits 0 and 1 set are driven together. The status word must then show stopped rather than running. Both outcomes are judged through status and interrupt reads in the scoreboard and through direct samples of `irq` half a cycle after the edge.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
   // register word indices (byte offset / 4)
   localparam logic [5:0] RI_DATA = 6'h00;
   localparam logic [5:0] RI_SDESC = 6'h16;
   localparam logic [5:0] RI_SBUF = 6'h17;
   localparam logic [5:0] RI_GRP = 6'h18;
   localparam logic [5:0] RI_GDN = 6'h1F;
   localparam logic [5:0] RI_CMD = 6'h20;
   localparam logic [5:0] RI_CFG = 6'h21;
   localparam logic [5:0] RI_STAT = 6'h22;
   localparam logic [5:0] RI_MASK = 6'h23;
   localparam logic [5:0] RI_ACK = 6'h24;
   localparam logic [5:0] RI_RAW = 6'h25;
   localparam logic [5:0] RI_MSK = 6'h26;
   localparam logic [5:0] RI_SCMD = 6'h27;

   localparam int WIN_SHIFT = 13;

   localparam logic [9:0] SC_LOAD_MASK = 10'h140;
   localparam int SC_BURST_BIT = 5;

   typedef enum logic [2:0] {
      ST_RST = 3'b001,
      ST_STOP = 3'b010,
      ST_RUN = 3'b100
   } chst_t;
endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode #(
   parameter int NCH = 4,
   parameter int CHB = 2,
   parameter int AW = 15
) (
   input logic bus_valid,
   input logic bus_write,
   input logic [AW-1:0] bus_addr,
   input logic [3:0] bus_be,
   output logic [CHB-1:0] ch_idx,
   output logic [5:0] reg_idx,
   output logic ch_ok,
   output logic full,
   output logic [NCH-1:0] wr_sel
);
   import dmareg_pkg::*;

   logic unused_addr;
   assign unused_addr = ^{bus_addr[12:8], bus_addr[1:0]};

   assign ch_idx = bus_addr[WIN_SHIFT +: CHB];
   assign reg_idx = bus_addr[7:2];
   assign full = (bus_be == 4'hF);

   generate
      if ((1 << CHB) == NCH) begin : g_pow2
         assign ch_ok = 1'b1;
      end else begin : g_npow2
         assign ch_ok = (int'(ch_idx) < NCH);
      end
   endgenerate

   for (genvar c = 0; c < NCH; c++) begin : g_sel
      assign wr_sel[c] = bus_valid && bus_write && full && ch_ok
                         && (int'(ch_idx) == c);
   end
endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan #(
   parameter int IRQ_W = 4,
   parameter int SRC_W = 2
) (
   input logic clk,
   input logic rst_n,
   input logic wr_en,
   input logic [5:0] reg_idx,
   input logic [31:0] wdata,
   input logic [IRQ_W-1:0] irq_set,
   input logic eol_in,
   input logic run_set,
   input logic [SRC_W-1:0] src_in,
   output logic [31:0] rd_word,
   output logic irq,
   output logic cont_pulse,
   output logic cmd_bad,
   output logic load_desc,
   output logic start_burst
);
   import dmareg_pkg::*;

   logic [31:0] data_q, sdesc_q, sbuf_q, grp_q, gdn_q, cmd_q, cfg_q, mask_q, scmd_q;
   logic [IRQ_W-1:0] raw_q, msk_q, raw_nx, msk_nx, ack_bits, mask_lo;
   chst_t st_q, st_nx;
   logic irq_q;

   wire wr_cfg = wr_en && (reg_idx == RI_CFG);
   wire wr_ack = wr_en && (reg_idx == RI_ACK);
   wire wr_mask = wr_en && (reg_idx == RI_MASK);
   wire wr_cmd = wr_en && (reg_idx == RI_CMD);
   wire wr_scmd = wr_en && (reg_idx == RI_SCMD);

   always_comb begin
      ack_bits = wr_ack ? wdata[IRQ_W-1:0] : '0;
      mask_lo = wr_mask ? wdata[IRQ_W-1:0] : mask_q[IRQ_W-1:0];
      raw_nx = (raw_q & ~ack_bits) | irq_set;   // set beats ack
      msk_nx = raw_nx & mask_lo;
      st_nx = st_q;
      if (wr_cfg) begin
         if (!wdata[0]) st_nx = ST_RST;
         else if (wdata[1]) st_nx = ST_STOP;
      end else if (run_set) begin
         st_nx = ST_RUN;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0; sdesc_q <= '0; sbuf_q <= '0; grp_q <= '0; gdn_q <= '0;
         cmd_q <= '0; cfg_q <= '0; mask_q <= '0; scmd_q <= '0;
         raw_q <= '0; msk_q <= '0; irq_q <= 1'b0; st_q <= ST_RST;
         cont_pulse <= 1'b0; cmd_bad <= 1'b0; load_desc <= 1'b0; start_burst <= 1'b0;
      end else begin
         raw_q <= raw_nx;
         msk_q <= msk_nx;
         irq_q <= |msk_nx;
         st_q <= st_nx;
         if (wr_en) begin
            case (reg_idx)
               RI_DATA: data_q <= wdata;
               RI_SDESC: sdesc_q <= wdata;
               RI_SBUF: sbuf_q <= wdata;
               RI_GRP: grp_q <= wdata;
               RI_GDN: gdn_q <= wdata;
               RI_CMD: cmd_q <= wdata;
               RI_CFG: cfg_q <= wdata;
               RI_MASK: mask_q <= wdata;
               RI_SCMD: scmd_q <= wdata;
               default: ;
            endcase
         end
         cont_pulse <= wr_cmd;
         cmd_bad <= wr_cmd && (|wdata[31:1]);
         load_desc <= wr_scmd && (|(wdata[9:0] & SC_LOAD_MASK));
         start_burst <= wr_scmd && (|(wdata[9:0] & SC_LOAD_MASK)) && wdata[SC_BURST_BIT];
      end
   end

   assign irq = irq_q;

   always_comb begin
      rd_word = '0;
      case (reg_idx)
         RI_DATA: rd_word = data_q;
         RI_SDESC: rd_word = sdesc_q;
         RI_SBUF: rd_word = sbuf_q;
         RI_GRP: rd_word = grp_q;
         RI_GDN: rd_word = gdn_q;
         RI_CMD: rd_word = cmd_q;
         RI_CFG: rd_word = cfg_q;
         RI_MASK: rd_word = mask_q;
         RI_SCMD: rd_word = scmd_q;
         RI_RAW: rd_word = 32'(raw_q);
         RI_MSK: rd_word = 32'(msk_q);
         RI_STAT: begin
            rd_word[2:0] = st_q;
            rd_word[5] = eol_in;
            rd_word[8 +: SRC_W] = src_in;
         end
         default: rd_word = '0;   // includes the acknowledge register
      endcase
   end

   a_r3_state_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(st_q) == 1);
   a_r3_cfg_forces_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cfg && !wdata[0]) |=> (st_q == ST_RST));
   a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ack && irq_set == '0) |=> ((raw_q & $past(wdata[IRQ_W-1:0])) == '0));
   a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_set) |=> ((raw_q & $past(irq_set)) == $past(irq_set)));
   a_r6_irq_line: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (msk_q != '0));
   a_r6_masked_in_raw: assert property (@(posedge clk) disable iff (!rst_n)
      (msk_q & ~raw_q) == '0);
   a_r8_bad_with_cont: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_bad |-> cont_pulse);
   a_r9_burst_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
      start_burst |-> load_desc);
endmodule

// File: rtl/dmareg_bank.sv
module dmareg_bank #(
   parameter int NCH = 4,
   parameter int IRQ_W = 4,
   parameter int SRC_W = 2,
   localparam int CHB = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int AW = 13 + CHB
) (
   input logic clk,
   input logic rst_n,
   input logic bus_valid,
   input logic bus_write,
   input logic [AW-1:0] bus_addr,
   input logic [3:0] bus_be,
   input logic [31:0] bus_wdata,
   output logic rd_valid,
   output logic [31:0] rd_data,
   output logic bus_err,
   input logic [NCH*IRQ_W-1:0] eng_irq_set,
   input logic [NCH-1:0] eng_eol,
   input logic [NCH-1:0] eng_run,
   input logic [NCH*SRC_W-1:0] cmd_src,
   output logic [NCH-1:0] irq,
   output logic [NCH-1:0] cont_pulse,
   output logic [NCH-1:0] cmd_bad,
   output logic [NCH-1:0] desc_load,
   output logic [NCH-1:0] burst_start
);
   if (NCH < 1 || NCH > 64) begin : g_bad_nch
      $error("dmareg_bank: NCH out of range");
   end
   if (IRQ_W < 1 || IRQ_W > 32) begin : g_bad_irqw
      $error("dmareg_bank: IRQ_W out of range");
   end
   if (SRC_W < 1 || SRC_W > 24) begin : g_bad_srcw
      $error("dmareg_bank: SRC_W out of range");
   end

   logic [CHB-1:0] ch_idx;
   logic [5:0] reg_idx;
   logic ch_ok, full;
   logic [NCH-1:0] wr_sel;
   logic [31:0] chan_rd [NCH];

   dmareg_decode #(.NCH(NCH), .CHB(CHB), .AW(AW)) u_dec (
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_be(bus_be), .ch_idx(ch_idx), .reg_idx(reg_idx), .ch_ok(ch_ok),
      .full(full), .wr_sel(wr_sel));

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      dmareg_chan #(.IRQ_W(IRQ_W), .SRC_W(SRC_W)) u_ch (
         .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[c]), .reg_idx(reg_idx),
         .wdata(bus_wdata), .irq_set(eng_irq_set[c*IRQ_W +: IRQ_W]),
         .eol_in(eng_eol[c]), .run_set(eng_run[c]),
         .src_in(cmd_src[c*SRC_W +: SRC_W]), .rd_word(chan_rd[c]),
         .irq(irq[c]), .cont_pulse(cont_pulse[c]), .cmd_bad(cmd_bad[c]),
         .load_desc(desc_load[c]), .start_burst(burst_start[c]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data <= '0;
         bus_err <= 1'b0;
      end else begin
         rd_valid <= bus_valid && !bus_write;
         bus_err <= bus_valid && !full;
         if (bus_valid && !bus_write)
            rd_data <= (full && ch_ok) ? chan_rd[ch_idx] : '0;
      end
   end

   a_r10_narrow_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_err && rd_valid) |-> (rd_data == '0));
endmodule

// File: tb/dmareg_bank_test.sv
`timescale 1ns/100ps
module dmareg_bank_test;
   localparam int NCH = 4, IRQ_W = 4, SRC_W = 2, AW = 15;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_valid = 0, bus_write = 0;
   logic [AW-1:0] bus_addr = '0;
   logic [3:0] bus_be = 4'hF;
   logic [31:0] bus_wdata = '0;
   logic rd_valid, bus_err;
   logic [31:0] rd_data;
   logic [NCH*IRQ_W-1:0] eng_irq_set = '0;
   logic [NCH-1:0] eng_eol = '0, eng_run = '0;
   logic [NCH*SRC_W-1:0] cmd_src = {2'd3, 2'd1, 2'd2, 2'd1};
   logic [NCH-1:0] irq, cont_pulse, cmd_bad, desc_load, burst_start;

   int n_cmp = 0, n_bad = 0;
   logic [31:0] exp_q[$];
   string tag_q[$];
   int cyc = 0;

   always #2.5 clk = ~clk;

   dmareg_bank #(.NCH(NCH), .IRQ_W(IRQ_W), .SRC_W(SRC_W)) uut (.*);

   function automatic logic [AW-1:0] ad(input int ch, input int off);
      return AW'((ch << 13) | off);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int ch, input int off, input logic [31:0] v,
                     input logic [3:0] be = 4'hF);
      @(negedge clk);
      bus_valid = 1; bus_write = 1; bus_addr = ad(ch, off); bus_wdata = v; bus_be = be;
      @(negedge clk);
      bus_valid = 0; bus_write = 0; bus_be = 4'hF;
   endtask

   // driver: push the expected word, then issue the read
   task automatic rd(input int ch, input int off, input logic [31:0] exp,
                     input string tag, input logic [3:0] be = 4'hF);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      bus_valid = 1; bus_write = 0; bus_addr = ad(ch, off); bus_be = be;
      @(negedge clk);
      bus_valid = 0; bus_be = 4'hF;
   endtask

   task automatic run_pulse(input int ch);
      @(negedge clk); eng_run[ch] = 1;
      @(negedge clk); eng_run[ch] = 0;
   endtask

   task automatic set_pulse(input int ch, input logic [IRQ_W-1:0] v);
      @(negedge clk); eng_irq_set[ch*IRQ_W +: IRQ_W] = v;
      @(negedge clk); eng_irq_set = '0;
   endtask

   // monitor: pop and compare as read data arrives
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL unexpected read actual=%h expected=none", rd_data);
         end else begin
            chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=%0d expected<20000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // reset state (R4, R6)
      rd(0, 'h88, 32'h101, "R4 reset status ch0");
      rd(3, 'h88, 32'h301, "R4 reset status ch3");
      chk("R6 irq low after reset", 32'(irq), 32'h0);
      // R2 pointer registers
      wr(2, 'h00, 32'hA000_0010);
      wr(2, 'h58, 32'h1111_2222);
      wr(2, 'h5C, 32'h3333_4444);
      wr(2, 'h60, 32'h5555_6666);
      wr(2, 'h7C, 32'h7777_8888);
      rd(2, 'h00, 32'hA000_0010, "R2 data ptr");
      rd(2, 'h58, 32'h1111_2222, "R2 saved desc");
      rd(2, 'h5C, 32'h3333_4444, "R2 saved buf");
      rd(2, 'h60, 32'h5555_6666, "R2 group");
      rd(2, 'h7C, 32'h7777_8888, "R2 group down");
      rd(2, 'h40, 32'h0, "R2 unmapped reads zero");
      // R1 aliasing and channel isolation
      wr(1, 'h100, 32'h0000_1234);
      rd(1, 'h00, 32'h0000_1234, "R1 aliased write ch1");
      rd(0, 'h00, 32'h0, "R1 ch0 untouched");
      rd(1, 'h1F00 | 'h58, 32'h0, "R1 aliased read ch1 sdesc");
      // R3 state machine
      wr(0, 'h84, 32'h1);
      rd(0, 'h88, 32'h101, "R3 cfg=1 keeps reset");
      run_pulse(0);
      rd(0, 'h88, 32'h104, "R3 run pulse");
      wr(0, 'h84, 32'h3);
      rd(0, 'h88, 32'h102, "R3 cfg=3 stops");
      wr(0, 'h84, 32'h1);
      rd(0, 'h88, 32'h102, "R3 cfg=1 leaves stopped");
      wr(0, 'h84, 32'h2);
      rd(0, 'h88, 32'h101, "R3 bit0 clear wins");
      @(negedge clk);
      eng_run[0] = 1; bus_valid = 1; bus_write = 1; bus_addr = ad(0, 'h84); bus_wdata = 32'h3;
      @(negedge clk);
      eng_run[0] = 0; bus_valid = 0; bus_write = 0;
      rd(0, 'h88, 32'h102, "R3 cfg beats run pulse");
      rd(0, 'h84, 32'h3, "R2 cfg readback");
      // R4 eol and read-only
      @(negedge clk); eng_eol[0] = 1;
      rd(0, 'h88, 32'h122, "R4 eol bit5");
      wr(0, 'h88, 32'hFFFF_FFFF);
      rd(0, 'h88, 32'h122, "R4 status ignores write");
      // R6 masking
      wr(1, 'h8C, 32'h5);
      set_pulse(1, 4'h2);
      chk("R6 masked-off bit no irq", 32'(irq[1]), 32'h0);
      rd(1, 'h94, 32'h2, "R6 raw");
      rd(1, 'h98, 32'h0, "R6 masked zero");
      set_pulse(1, 4'h4);
      chk("R6 irq high", 32'(irq[1]), 32'h1);
      rd(1, 'h98, 32'h4, "R6 masked");
      wr(1, 'h94, 32'h0);
      wr(1, 'h98, 32'h0);
      rd(1, 'h94, 32'h6, "R6 raw ignores write");
      // R5 acknowledge
      wr(1, 'h90, 32'h4);
      chk("R5 ack drops irq", 32'(irq[1]), 32'h0);
      rd(1, 'h94, 32'h2, "R5 raw after ack");
      rd(1, 'h90, 32'h0, "R5 ack reads zero");
      wr(1, 'h8C, 32'h2);
      chk("R6 mask write raises irq", 32'(irq[1]), 32'h1);
      wr(1, 'h90, 32'h2);
      chk("R5 ack clears irq", 32'(irq[1]), 32'h0);
      // R7 set and ack together
      @(negedge clk);
      eng_irq_set[1*IRQ_W +: IRQ_W] = 4'h2;
      bus_valid = 1; bus_write = 1; bus_addr = ad(1, 'h90); bus_wdata = 32'h2;
      @(negedge clk);
      eng_irq_set = '0; bus_valid = 0; bus_write = 0;
      chk("R7 set wins irq", 32'(irq[1]), 32'h1);
      rd(1, 'h94, 32'h2, "R7 set wins raw");
      wr(1, 'h90, 32'h2);
      chk("R7 later ack clears", 32'(irq[1]), 32'h0);
      // R8 command
      wr(3, 'h80, 32'h1);
      chk("R8 cont pulse", 32'(cont_pulse), 32'h8);
      chk("R8 no bad", 32'(cmd_bad), 32'h0);
      @(negedge clk);
      chk("R8 pulse one cycle", 32'(cont_pulse), 32'h0);
      wr(3, 'h80, 32'h3);
      chk("R8 bad flagged", 32'(cmd_bad), 32'h8);
      chk("R8 cont with bad", 32'(cont_pulse), 32'h8);
      rd(3, 'h80, 32'h3, "R2 cmd readback");
      // R9 stream command
      wr(2, 'h9C, 32'h140);
      chk("R9 load only", {30'b0, burst_start[2], desc_load[2]}, 32'h1);
      wr(2, 'h9C, 32'h160);
      chk("R9 load and burst", {30'b0, burst_start[2], desc_load[2]}, 32'h3);
      wr(2, 'h9C, 32'h020);
      chk("R9 burst alone", {30'b0, burst_start[2], desc_load[2]}, 32'h0);
      wr(2, 'h9C, 32'h100);
      chk("R9 load bit8", {30'b0, burst_start[2], desc_load[2]}, 32'h1);
      rd(2, 'h9C, 32'h100, "R2 stream cmd readback");
      // R10 narrow access
      wr(2, 'h00, 32'hDEAD_BEEF, 4'h3);
      chk("R10 write err", 32'(bus_err), 32'h1);
      rd(2, 'h00, 32'hA000_0010, "R10 narrow write ignored");
      rd(2, 'h00, 32'h0, "R10 narrow read zero", 4'h1);
      chk("R10 read err", 32'(bus_err), 32'h1);
      repeat (4) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_cmp++; n_bad++;
         $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule